// File: doc/BRIEF.md
# Bandwidth-Quota DMA Channel Arbiter

This block decides which of four DMA channels owns a shared transfer engine. Each channel presents a request and a two-bit priority. Among the requesters at the highest priority present, the arbiter picks one in round-robin order, starting after the channel granted most recently. The grant is a registered one-hot vector with a matching channel index.

Once granted, a channel keeps the engine until one of two things happens. Either its transfer finishes, signalled by `xfer_done`, or it uses up its byte allowance. Each channel has its own programmable 16-bit byte quota. The quota is loaded when the grant is issued, and the engine reports the bytes moved on each beat. When a beat uses up the remaining allowance, the grant is withdrawn and a one-cycle exhaustion pulse marks the channel. A quota of zero means the channel is not limited. The next arbitration takes place only after the engine is free again, so a channel that yields cannot hold on to the engine. It can still win again later if it keeps requesting.

Top module: `dma_quota_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `grant_id` is 0 and `quota_exhausted` is 0. The round-robin pointer starts so that channel 0 is searched first.
- R2: At most one `grant` bit is set at any time. `grant_id` is the index of the set bit, and 0 when no bit is set. The grant does not change while a channel owns the engine.
- R3: Priority codes map to levels as follows: 0 is low, 1 is medium, and both 2 and 3 are high. Only requesters at the highest level present can be granted.
- R4: Ties at that level are broken round-robin. The search starts at the channel after the most recently granted one and wraps from channel 3 to channel 0.
- R5: The arbiter decides a grant only in a cycle when no channel owns the engine. A request seen in such a cycle is granted from the next cycle on.
- R6: On a new grant, the channel's 16-bit quota (bits [16c+15:16c] of `quota`) is loaded. Every cycle with `beat_valid` subtracts `beat_bytes`. A beat whose byte count is at least the remaining quota clears the grant at that edge and sets `quota_exhausted[c]` for exactly the following cycle.
- R7: `xfer_done` while a channel owns the engine clears the grant at that edge, with no exhaustion pulse if the quota is not used up. The following idle cycle arbitrates, so a waiting request is granted one cycle after the grant drops.
- R8: A quota of zero loaded at grant time means no limit. Beats of any size never cause an exhaustion pulse or a release.
- R9: When `xfer_done` and a quota-exhausting beat occur in the same cycle, the grant is released once and the exhaustion pulse still fires.
- R10: A channel that yielded on quota is re-granted in a later arbitration if it still requests and no other candidate precedes it.
- R11: `beat_valid`, `beat_bytes` and `xfer_done` have no effect while no channel owns the engine. With no request, `grant` and `quota_exhausted` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Per-channel request |
| prio | input | 8 | Two-bit priority per channel, channel c at [2c+1:2c] |
| quota | input | 64 | 16-bit byte quota per channel, channel c at [16c+15:16c] |
| beat_valid | input | 1 | Engine moved one beat this cycle |
| beat_bytes | input | 8 | Bytes moved by that beat |
| xfer_done | input | 1 | Current owner's transfer finished |
| grant | output | 4 | One-hot grant |
| grant_id | output | 2 | Index of granted channel |
| quota_exhausted | output | 4 | One-cycle pulse for the channel that ran out of quota |

## Verification
The end of a transfer and the exhaustion of its quota can fall in the same cycle. Both try to release the engine, and only the exhaustion produces a pulse. This collision is provoked directly by a beat that exactly consumes the remaining quota together with `xfer_done`. It also arises in random traffic that mixes small quotas, frequent beats and occasional done signals. It is judged by a bench model that expects a single release, the pulse on the owning channel in the following cycle, and a fresh arbitration one cycle later.

// File: rtl/dqa_pkg.sv
package dqa_pkg;

  localparam int PRIO_W  = 2;
  localparam int LEVEL_W = 2;

  typedef logic [LEVEL_W-1:0] level_t;

  // priority code to level: 3 folds onto high (2)
  function automatic level_t level_of(input logic [PRIO_W-1:0] code);
    level_t lv;
    if (code == 2'd3) lv = 2'd2;
    else              lv = level_t'(code);
    return lv;
  endfunction

  // true when a beat of 'bytes' consumes everything left in 'rem'
  function automatic logic quota_spent(input logic [31:0] rem, input logic [31:0] bytes);
    return (bytes >= rem);
  endfunction

  // remaining quota after a beat that does not exhaust it
  function automatic logic [31:0] quota_after(input logic [31:0] rem, input logic [31:0] bytes);
    return rem - bytes;
  endfunction

endpackage

// File: rtl/dqa_level_filter.sv
module dqa_level_filter #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]                 req,
  input  logic [NUM_CH*dqa_pkg::PRIO_W-1:0] prio,
  output logic [NUM_CH-1:0]                 cand
);
  import dqa_pkg::*;

  level_t lvl [NUM_CH];
  level_t top_lvl;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lvl
      assign lvl[g] = level_of(prio[g*PRIO_W +: PRIO_W]);
    end
  endgenerate

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (lvl[i] > top_lvl)) top_lvl = lvl[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cand[i] = req[i] && (lvl[i] == top_lvl);
    end
  end

endmodule

// File: rtl/dqa_rr_pick.sv
module dqa_rr_pick #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cand,
  input  logic [IDX_W-1:0]  last,
  output logic [IDX_W-1:0]  win_idx,
  output logic              win_valid
);

  always_comb begin
    logic found;
    int   pos;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      pos = int'(last) + k;
      if (pos >= NUM_CH) pos = pos - NUM_CH;
      if (!found && cand[pos]) begin
        found   = 1'b1;
        win_idx = IDX_W'(pos);
      end
    end
    win_valid = found;
  end

  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]); // R4
  AST_CAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> win_valid); // R3

endmodule

// File: rtl/dqa_quota_track.sv
module dqa_quota_track #(
  parameter int QUOTA_W = 16,
  parameter int BEAT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [QUOTA_W-1:0] load_quota,
  input  logic               active,
  input  logic               beat_valid,
  input  logic [BEAT_W-1:0]  beat_bytes,
  output logic               exhaust_ev,
  output logic               unlimited
);
  import dqa_pkg::*;

  logic [QUOTA_W-1:0] rem_q;
  logic               unl_q;
  logic               spent;

  assign spent      = quota_spent(32'(rem_q), 32'(beat_bytes));
  assign exhaust_ev = active && !unl_q && beat_valid && spent;
  assign unlimited  = unl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      unl_q <= 1'b0;
    end else if (load) begin
      rem_q <= load_quota;
      unl_q <= (load_quota == '0);
    end else if (active && beat_valid && !spent) begin
      rem_q <= QUOTA_W'(quota_after(32'(rem_q), 32'(beat_bytes)));
    end
  end

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !unl_q) |-> (rem_q != '0)); // R6
  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (unl_q == (rem_q == '0))); // R8

endmodule

// File: rtl/dma_quota_arbiter.sv
module dma_quota_arbiter #(
  parameter int NUM_CH  = 4,
  parameter int QUOTA_W = 16,
  parameter int BEAT_W  = 8,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CH-1:0]                 req,
  input  logic [NUM_CH*dqa_pkg::PRIO_W-1:0] prio,
  input  logic [NUM_CH*QUOTA_W-1:0]         quota,
  input  logic                              beat_valid,
  input  logic [BEAT_W-1:0]                 beat_bytes,
  input  logic                              xfer_done,
  output logic [NUM_CH-1:0]                 grant,
  output logic [IDX_W-1:0]                  grant_id,
  output logic [NUM_CH-1:0]                 quota_exhausted
);

  logic [NUM_CH-1:0]  cand;
  logic [IDX_W-1:0]   win_idx;
  logic               win_valid;
  logic               busy_q;
  logic [IDX_W-1:0]   owner_q;
  logic [IDX_W-1:0]   last_q;
  logic [NUM_CH-1:0]  grant_q;
  logic [IDX_W-1:0]   id_q;
  logic [NUM_CH-1:0]  exh_q;
  logic               exhaust_ev;
  logic               unlimited;
  logic               start_ev;
  logic               release_ev;
  logic [QUOTA_W-1:0] win_quota;

  dqa_level_filter #(.NUM_CH(NUM_CH)) u_filter (
    .req  (req),
    .prio (prio),
    .cand (cand)
  );

  dqa_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand),
    .last      (last_q),
    .win_idx   (win_idx),
    .win_valid (win_valid)
  );

  assign win_quota  = quota[win_idx*QUOTA_W +: QUOTA_W];
  assign start_ev   = !busy_q && win_valid;
  assign release_ev = busy_q && (exhaust_ev || xfer_done);

  dqa_quota_track #(.QUOTA_W(QUOTA_W), .BEAT_W(BEAT_W)) u_quota (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_ev),
    .load_quota (win_quota),
    .active     (busy_q),
    .beat_valid (beat_valid),
    .beat_bytes (beat_bytes),
    .exhaust_ev (exhaust_ev),
    .unlimited  (unlimited)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= IDX_W'(NUM_CH - 1);
      grant_q <= '0;
      id_q    <= '0;
      exh_q   <= '0;
    end else begin
      exh_q <= '0;
      if (exhaust_ev) exh_q[owner_q] <= 1'b1;
      if (release_ev) begin
        busy_q  <= 1'b0;
        grant_q <= '0;
        id_q    <= '0;
      end else if (start_ev) begin
        busy_q  <= 1'b1;
        owner_q <= win_idx;
        last_q  <= win_idx;
        grant_q <= NUM_CH'(1) << win_idx;
        id_q    <= win_idx;
      end
    end
  end

  assign grant           = grant_q;
  assign grant_id        = id_q;
  assign quota_exhausted = exh_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R2
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0) |-> grant_q[id_q]); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !release_ev) |=> $stable(grant_q)); // R2
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> req[win_idx]); // R5
  AST_EXHAUST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_ev |=> ((grant_q == '0) && (exh_q != '0))); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (exh_q != '0) |=> (exh_q == '0)); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && xfer_done) |=> !busy_q); // R7
  AST_UNLIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && unlimited && !xfer_done) |=> busy_q); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> (exh_q == '0)); // R11

endmodule

// File: tb/sim_dma_quota_arbiter.sv
module sim_dma_quota_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  prio = '0;
  logic [63:0] quota = '0;
  logic        beat_valid = 1'b0;
  logic [7:0]  beat_bytes = '0;
  logic        xfer_done = 1'b0;
  logic [3:0]  grant;
  logic [1:0]  grant_id;
  logic [3:0]  quota_exhausted;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  dma_quota_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .quota(quota),
    .beat_valid(beat_valid), .beat_bytes(beat_bytes), .xfer_done(xfer_done),
    .grant(grant), .grant_id(grant_id), .quota_exhausted(quota_exhausted)
  );

  // ---------------- reference model ----------------
  bit         m_busy;
  int         m_owner, m_last, m_rem;
  bit         m_unl;
  logic [3:0] m_grant, m_exh;
  logic [1:0] m_id;

  function automatic int rank(input logic [1:0] code);
    return (code >= 2) ? 2 : int'(code);
  endfunction

  function automatic int choose(input logic [3:0] r, input logic [7:0] p, input int last);
    for (int lv = 2; lv >= 0; lv--) begin
      for (int k = 1; k <= 4; k++) begin
        int c;
        c = (last + k) % 4;
        if (r[c] && rank(p[2*c +: 2]) == lv) return c;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_owner = 0; m_last = 3; m_rem = 0; m_unl = 0;
      m_grant = '0; m_exh = '0; m_id = '0;
    end else begin
      m_exh = '0;
      if (m_busy) begin
        bit ex;
        ex = !m_unl && beat_valid && (int'(beat_bytes) >= m_rem);
        if (ex) m_exh[m_owner] = 1'b1;
        if (beat_valid && !ex) m_rem = m_rem - int'(beat_bytes);
        if (ex || xfer_done) begin
          m_busy = 0; m_grant = '0; m_id = '0;
        end
      end else begin
        int w;
        w = choose(req, prio, m_last);
        if (w >= 0) begin
          m_busy = 1; m_owner = w; m_last = w;
          m_grant = 4'(1 << w); m_id = 2'(w);
          m_rem = int'(quota[16*w +: 16]); m_unl = (m_rem == 0);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 grant vs model", 32'(grant), 32'(m_grant));
      check("R2 grant_id vs model", 32'(grant_id), 32'(m_id));
      check("R6 quota_exhausted vs model", 32'(quota_exhausted), 32'(m_exh));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_q(input int ch, input int val);
    quota[16*ch +: 16] = 16'(val);
  endtask

  task automatic expect_out(input string tag, input logic [3:0] g, input logic [3:0] e);
    check(tag, 32'(grant), 32'(g));
    check(tag, 32'(quota_exhausted), 32'(e));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    // R1: reset state
    check("R1 grant", 32'(grant), 0);
    check("R1 grant_id", 32'(grant_id), 0);
    check("R1 quota_exhausted", 32'(quota_exhausted), 0);
    rst_n = 1'b1;
    step();
    check("R1 idle after reset", 32'(grant), 0);

    // R3/R5: ch0 low, ch1 medium, ch2 code 3, ch3 code 2
    set_q(0, 0); set_q(1, 0); set_q(2, 8); set_q(3, 10);
    prio = {2'd2, 2'd3, 2'd1, 2'd0};
    req  = 4'b1111;
    step();
    expect_out("R3 high level wins, code 3 as high", 4'b0100, 4'b0000);
    check("R2 grant_id is 2", 32'(grant_id), 2);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    expect_out("R7 done releases, no pulse", 4'b0000, 4'b0000);
    step();
    expect_out("R4 round robin moves to ch3", 4'b1000, 4'b0000);
    // R6: quota 10 on ch3
    beat_valid = 1'b1; beat_bytes = 8'd4;
    step();
    expect_out("R6 partial beat keeps grant", 4'b1000, 4'b0000);
    beat_bytes = 8'd6;
    step();
    beat_valid = 1'b0;
    expect_out("R6 exhausted: grant drops, pulse", 4'b0000, 4'b1000);
    step();
    expect_out("R6 pulse one cycle, ch2 next", 4'b0100, 4'b0000);
    // R9: ch2 quota 8, exact beat plus done
    beat_valid = 1'b1; beat_bytes = 8'd8; xfer_done = 1'b1;
    step();
    beat_valid = 1'b0; xfer_done = 1'b0;
    expect_out("R9 done with exhaust: pulse still fires", 4'b0000, 4'b0100);
    // R10: only ch3 requests, yields then re-granted
    req = 4'b1000;
    step();
    expect_out("R10 ch3 granted", 4'b1000, 4'b0000);
    beat_valid = 1'b1; beat_bytes = 8'd200;
    step();
    beat_valid = 1'b0;
    expect_out("R10 ch3 exhausted", 4'b0000, 4'b1000);
    set_q(3, 0);
    step();
    expect_out("R10 ch3 re-granted", 4'b1000, 4'b0000);
    // release, regrant with unlimited quota
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    step();
    expect_out("R8 ch3 granted with zero quota", 4'b1000, 4'b0000);
    for (int i = 0; i < 4; i++) begin
      beat_valid = 1'b1; beat_bytes = 8'd255;
      step();
      expect_out("R8 unlimited never exhausts", 4'b1000, 4'b0000);
    end
    beat_valid = 1'b0;
    req = 4'b0000; xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    expect_out("R7 release on done", 4'b0000, 4'b0000);
    // R11: idle beats and done are ignored
    beat_valid = 1'b1; beat_bytes = 8'd1; xfer_done = 1'b1;
    step(); step();
    beat_valid = 1'b0; xfer_done = 1'b0;
    expect_out("R11 idle beat/done no effect", 4'b0000, 4'b0000);
    // R3: medium beats low
    prio = {2'd0, 2'd0, 2'd1, 2'd0};
    req = 4'b0011;
    step();
    expect_out("R3 medium beats low", 4'b0010, 4'b0000);
    req = 4'b0000; xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    step();

    // random traffic, checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      req  = 4'($urandom);
      if ($urandom_range(0, 3) == 0) prio = 8'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        for (int c = 0; c < 4; c++)
          set_q(c, ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 60));
      end
      beat_valid = ($urandom_range(0, 9) < 7);
      beat_bytes = 8'($urandom_range(0, 32));
      xfer_done  = ($urandom_range(0, 19) == 0);
      step();
    end
    req = '0; beat_valid = 1'b0; xfer_done = 1'b0;
    step(); step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule